// File: doc/BRIEF.md
# Floating-point atomic read-modify-write unit

This block holds a small local store of 32-bit IEEE single-precision words and applies one atomic operation at a time to them: minimum, maximum, exchange or compare-and-swap. A requester presents a request with an opcode, a word address, a data operand and a compare operand under a valid/ready handshake. The unit reads the addressed word, computes the replacement, writes it back and returns the word's previous contents on a one-cycle response strobe.

Only one request is in flight at a time. Each operation takes a read cycle and then a write cycle, and `req_ready` is low during both. Two requests to the same word therefore always see each other's effects in issue order.

Minimum and maximum order signed zeros and follow a fixed NaN policy. A signaling NaN always dominates. A quiet NaN gives way to any other operand. Compare-and-swap uses floating-point equality, not bit equality.

Top module: `fatomic_rmw`

## Requirements
- R1: After reset every word of the store reads +0.0 (0x00000000), `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the cycle after acceptance, `req_ready` and `rsp_valid` are both low. In the cycle after that, `rsp_valid` is high for exactly one cycle, and `req_ready` returns high in the following cycle.
- R3: Opcode encoding on `req_op` is 0 = minimum, 1 = maximum, 2 = exchange, 3 = compare-and-swap. Every operation returns on `rsp_data` the word as it was before the update.
- R4: For non-NaN operands, minimum stores the smaller value and maximum stores the larger value. Negative values, infinities and denormals are ordered as ordinary numbers, with no flush to zero.
- R5: Minimum of +0.0 and -0.0 (0x80000000) stores -0.0 whichever operand is in memory. Maximum of the pair stores +0.0.
- R6: A word is a NaN when its exponent field is all ones and its mantissa is nonzero. It is quiet when mantissa bit 22 is set and signaling otherwise. For minimum or maximum, if exactly one operand is a quiet NaN and the other is not a NaN, the non-NaN operand is stored.
- R7: For minimum or maximum, if exactly one operand is a signaling NaN, that signaling NaN is stored, whether the other operand is a number or a quiet NaN.
- R8: For minimum or maximum, if both operands are NaNs of the same kind, the memory word is kept unchanged.
- R9: Exchange stores the data operand bit for bit, including any NaN payload and sign.
- R10: Compare-and-swap stores the data operand when the memory word equals the compare operand in floating-point terms. +0.0 and -0.0 count as equal. Otherwise the word is left unchanged.
- R11: Compare-and-swap never writes when the memory word or the compare operand is a NaN, even if the bit patterns are identical.
- R12: Requests issued back to back to the same address take effect in issue order. Each one returns the value left by the one before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 2 | Operation code |
| req_addr | input | AW (4) | Word address |
| req_data | input | 32 | Data operand |
| req_cmp | input | 32 | Compare operand for compare-and-swap |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_data | output | 32 | Word contents before the operation |

## Verification
A wrong stored word never shows up on the operation that writes it. It shows up only when the same address is next touched, because the old value comes back on `rsp_data` two cycles after that later request is accepted. The bench therefore follows each interesting update with a probe: a compare-and-swap with a NaN compare operand, which returns the word without changing it. A broken handshake sequence is visible at once, in the cycles right after acceptance, as a wrong level on `req_ready` or `rsp_valid`.

// File: rtl/fatomic_pkg.sv
package fatomic_pkg;

  localparam int FP_W = 32;

  typedef enum logic [1:0] {
    OP_MIN  = 2'd0,
    OP_MAX  = 2'd1,
    OP_XCHG = 2'd2,
    OP_CAS  = 2'd3
  } fa_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } fa_state_e;

  function automatic logic is_nan(input logic [FP_W-1:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction

  function automatic logic is_qnan(input logic [FP_W-1:0] x);
    return is_nan(x) && x[22];
  endfunction

  function automatic logic is_snan(input logic [FP_W-1:0] x);
    return is_nan(x) && !x[22];
  endfunction

  // Monotone unsigned key: -0.0 sorts just below +0.0.
  function automatic logic [FP_W-1:0] order_key(input logic [FP_W-1:0] x);
    return x[31] ? ~x : (x ^ 32'h8000_0000);
  endfunction

  function automatic logic fp_less(input logic [FP_W-1:0] a, input logic [FP_W-1:0] b);
    return order_key(a) < order_key(b);
  endfunction

  function automatic logic fp_equal(input logic [FP_W-1:0] a, input logic [FP_W-1:0] b);
    logic both_zero;
    both_zero = (a[30:0] == 31'd0) && (b[30:0] == 31'd0);
    return !is_nan(a) && !is_nan(b) && ((a == b) || both_zero);
  endfunction

endpackage

// File: rtl/fatomic_mem.sv
module fatomic_mem #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data
);

  logic [W-1:0] words_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
    end else if (wr_en) begin
      words_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = words_q[rd_addr];

endmodule

// File: rtl/fatomic_minmax.sv
module fatomic_minmax
  import fatomic_pkg::*;
(
  input  logic            pick_max,
  input  logic [FP_W-1:0] mem_val,
  input  logic [FP_W-1:0] arg_val,
  output logic [FP_W-1:0] result
);

  logic m_s, m_q, a_s, a_q;
  logic m_lt_a, a_lt_m;

  assign m_s    = is_snan(mem_val);
  assign m_q    = is_qnan(mem_val);
  assign a_s    = is_snan(arg_val);
  assign a_q    = is_qnan(arg_val);
  assign m_lt_a = fp_less(mem_val, arg_val);
  assign a_lt_m = fp_less(arg_val, mem_val);

  always_comb begin
    if (m_s)             result = mem_val;
    else if (a_s)        result = arg_val;
    else if (m_q && a_q) result = mem_val;
    else if (m_q)        result = arg_val;
    else if (a_q)        result = mem_val;
    else if (pick_max)   result = m_lt_a ? arg_val : mem_val;
    else                 result = a_lt_m ? arg_val : mem_val;
  end

  always_comb begin
    if (a_s && !m_s)
      a_r7_snan_dominates: assert (result == arg_val);
    if (m_q && !is_nan(arg_val))
      a_r6_qnan_yields: assert (result == arg_val);
    if (mem_val == 32'h8000_0000 && arg_val == 32'h0000_0000)
      a_r5_zero_order: assert (result == (pick_max ? arg_val : mem_val));
  end

endmodule

// File: rtl/fatomic_alu.sv
module fatomic_alu
  import fatomic_pkg::*;
(
  input  fa_op_e          op,
  input  logic [FP_W-1:0] old_val,
  input  logic [FP_W-1:0] data_val,
  input  logic [FP_W-1:0] cmp_val,
  output logic [FP_W-1:0] new_val,
  output logic            cas_hit
);

  logic [FP_W-1:0] mm_result;

  fatomic_minmax u_minmax (
    .pick_max (op == OP_MAX),
    .mem_val  (old_val),
    .arg_val  (data_val),
    .result   (mm_result)
  );

  assign cas_hit = fp_equal(old_val, cmp_val);

  always_comb begin
    unique case (op)
      OP_MIN, OP_MAX: new_val = mm_result;
      OP_XCHG:        new_val = data_val;
      OP_CAS:         new_val = cas_hit ? data_val : old_val;
      default:        new_val = old_val;
    endcase
  end

endmodule

// File: rtl/fatomic_rmw.sv
module fatomic_rmw
  import fatomic_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_data,
  input  logic [31:0]   req_cmp,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data
);

  fa_state_e       state_q;
  fa_op_e          op_q;
  logic [AW-1:0]   addr_q;
  logic [FP_W-1:0] data_q, cmp_q, old_q;
  logic [FP_W-1:0] mem_rdata, alu_new;
  logic            fire, cas_hit, mem_we;

  assign fire      = req_valid && req_ready;
  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_WRITE);
  assign rsp_data  = old_q;
  assign mem_we    = rsp_valid && ((op_q != OP_CAS) || cas_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_MIN;
      addr_q  <= '0;
      data_q  <= '0;
      cmp_q   <= '0;
      old_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fire) begin
          state_q <= ST_READ;
          op_q    <= fa_op_e'(req_op);
          addr_q  <= req_addr;
          data_q  <= req_data;
          cmp_q   <= req_cmp;
        end
        ST_READ: begin
          old_q   <= mem_rdata;
          state_q <= ST_WRITE;
        end
        ST_WRITE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  fatomic_mem #(.DEPTH(DEPTH), .W(FP_W), .AW(AW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (addr_q),
    .rd_data (mem_rdata),
    .wr_en   (mem_we),
    .wr_addr (addr_q),
    .wr_data (alu_new)
  );

  fatomic_alu u_alu (
    .op       (op_q),
    .old_val  (old_q),
    .data_val (data_q),
    .cmp_val  (cmp_q),
    .new_val  (alu_new),
    .cas_hit  (cas_hit)
  );

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!req_ready && !rsp_valid));
  a_r2_response_slot: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ##1 rsp_valid);
  a_r2_single_response: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  a_r11_cas_nan_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_CAS && (is_nan(old_q) || is_nan(cmp_q))) |-> !mem_we);
  a_r9_xchg_raw_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_XCHG) |-> (mem_we && alu_new == data_q));
  a_r3_returns_old: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (rsp_data == $past(mem_rdata)));

endmodule

// File: tb/fatomic_rmw_bench.sv
module fatomic_rmw_bench;

  localparam logic [31:0] PZ    = 32'h0000_0000;
  localparam logic [31:0] NZ    = 32'h8000_0000;
  localparam logic [31:0] QNAN  = 32'h7FC0_0000;
  localparam logic [31:0] QNAN2 = 32'hFFC0_1234;
  localparam logic [31:0] SNAN  = 32'h7F80_0001;
  localparam logic [31:0] SNAN2 = 32'hFF80_0055;
  localparam logic [31:0] ONE   = 32'h3F80_0000;
  localparam logic [31:0] TWO   = 32'h4000_0000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [1:0]  req_op = 0;
  logic [3:0]  req_addr = 0;
  logic [31:0] req_data = 0;
  logic [31:0] req_cmp = 0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int tests = 0;
  int fails = 0;
  logic [31:0] model [16];
  logic [31:0] got;

  always #5 clk = ~clk;

  fatomic_rmw u_fatomic_rmw (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_cmp(req_cmp),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic nan_b(input logic [31:0] x);
    return &x[30:23] && |x[22:0];
  endfunction
  function automatic logic sig_b(input logic [31:0] x);
    return nan_b(x) && (x[22] == 1'b0);
  endfunction
  function automatic logic quiet_b(input logic [31:0] x);
    return nan_b(x) && x[22];
  endfunction
  function automatic logic below(input logic [31:0] a, input logic [31:0] b);
    if (a[30:0] == 0 && b[30:0] == 0) return a[31] && !b[31];
    if (a[31] != b[31]) return a[31];
    if (!a[31]) return a[30:0] < b[30:0];
    return a[30:0] > b[30:0];
  endfunction
  function automatic logic same_val(input logic [31:0] a, input logic [31:0] b);
    if (nan_b(a) || nan_b(b)) return 1'b0;
    return (a == b) || (a[30:0] == 0 && b[30:0] == 0);
  endfunction
  function automatic logic [31:0] pick(input logic mx, input logic [31:0] m, input logic [31:0] d);
    if (sig_b(m)) return m;
    if (sig_b(d)) return d;
    if (nan_b(m) && nan_b(d)) return m;
    if (quiet_b(m)) return d;
    if (quiet_b(d)) return m;
    if (mx) return below(m, d) ? d : m;
    return below(d, m) ? d : m;
  endfunction
  function automatic logic [31:0] expect_new(input logic [1:0] op, input logic [31:0] o,
                                             input logic [31:0] d, input logic [31:0] c);
    case (op)
      2'd0: return pick(1'b0, o, d);
      2'd1: return pick(1'b1, o, d);
      2'd2: return d;
      default: return same_val(o, c) ? d : o;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input int a, input logic [31:0] d,
                       input logic [31:0] c, output logic [31:0] old);
    logic [31:0] exp_old;
    exp_old = model[a];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = 4'(a); req_data = d; req_cmp = c;
    @(posedge clk);
    #1 req_valid = 0;
    @(negedge clk);
    check({30'd0, req_ready, rsp_valid}, 32'd0, "R2 busy after accept");
    @(negedge clk);
    check({31'd0, rsp_valid}, 32'd1, "R2 response slot");
    check(rsp_data, exp_old, "R3 old value returned");
    old = rsp_data;
    model[a] = expect_new(op, exp_old, d, c);
  endtask

  task automatic peek(input int a, input logic [31:0] expv, input string req);
    logic [31:0] o;
    do_op(2'd3, a, 32'h1234_5678, QNAN, o);
    check(o, expv, req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check({30'd0, req_ready, rsp_valid}, 32'd2, "R1 handshake idle");
    peek(0, PZ, "R1 word 0");
    peek(15, PZ, "R1 word 15");
  endtask

  task automatic t_order();
    do_op(2'd2, 1, 32'h4040_0000, 0, got);
    do_op(2'd0, 1, 32'h3FC0_0000, 0, got);
    peek(1, 32'h3FC0_0000, "R4 min smaller");
    do_op(2'd1, 1, 32'hC000_0000, 0, got);
    peek(1, 32'h3FC0_0000, "R4 max ignores negative");
    do_op(2'd0, 1, 32'h0000_0001, 0, got);
    peek(1, 32'h0000_0001, "R4 denormal kept");
    do_op(2'd0, 1, 32'h8000_0001, 0, got);
    peek(1, 32'h8000_0001, "R4 negative denormal");
    do_op(2'd1, 1, 32'h7F80_0000, 0, got);
    peek(1, 32'h7F80_0000, "R4 +inf max");
  endtask

  task automatic t_zero();
    do_op(2'd0, 2, NZ, 0, got);
    peek(2, NZ, "R5 min(+0,-0)");
    do_op(2'd1, 2, PZ, 0, got);
    peek(2, PZ, "R5 max(-0,+0)");
    do_op(2'd1, 2, NZ, 0, got);
    peek(2, PZ, "R5 max(+0,-0)");
  endtask

  task automatic t_qnan();
    do_op(2'd2, 3, TWO, 0, got);
    do_op(2'd0, 3, QNAN, 0, got);
    peek(3, TWO, "R6 qnan argument ignored");
    do_op(2'd2, 3, QNAN2, 0, got);
    do_op(2'd1, 3, 32'h40A0_0000, 0, got);
    peek(3, 32'h40A0_0000, "R6 qnan in memory replaced");
  endtask

  task automatic t_snan();
    do_op(2'd2, 4, ONE, 0, got);
    do_op(2'd1, 4, SNAN, 0, got);
    peek(4, SNAN, "R7 snan argument wins");
    do_op(2'd2, 5, QNAN, 0, got);
    do_op(2'd0, 5, SNAN2, 0, got);
    peek(5, SNAN2, "R7 snan beats qnan");
    do_op(2'd2, 6, SNAN, 0, got);
    do_op(2'd0, 6, 32'hFF80_0000, 0, got);
    peek(6, SNAN, "R7 snan in memory kept");
  endtask

  task automatic t_same();
    do_op(2'd2, 7, QNAN, 0, got);
    do_op(2'd0, 7, QNAN2, 0, got);
    peek(7, QNAN, "R8 two qnans keep memory");
    do_op(2'd2, 8, SNAN, 0, got);
    do_op(2'd1, 8, SNAN2, 0, got);
    peek(8, SNAN, "R8 two snans keep memory");
  endtask

  task automatic t_xchg();
    do_op(2'd2, 9, SNAN2, 0, got);
    check(got, PZ, "R9 exchange returns old");
    peek(9, SNAN2, "R9 raw bits stored");
  endtask

  task automatic t_cas();
    do_op(2'd2, 10, TWO, 0, got);
    do_op(2'd3, 10, 32'h40E0_0000, TWO, got);
    peek(10, 32'h40E0_0000, "R10 equal compare swaps");
    do_op(2'd3, 10, ONE, 32'h4040_0000, got);
    peek(10, 32'h40E0_0000, "R10 unequal compare keeps");
    do_op(2'd3, 11, ONE, NZ, got);
    peek(11, ONE, "R10 -0 matches +0");
  endtask

  task automatic t_cas_nan();
    do_op(2'd2, 12, QNAN, 0, got);
    do_op(2'd3, 12, ONE, QNAN, got);
    peek(12, QNAN, "R11 identical nan fails");
    do_op(2'd2, 12, ONE, 0, got);
    do_op(2'd3, 12, TWO, SNAN, got);
    peek(12, ONE, "R11 nan compare fails");
  endtask

  task automatic t_b2b();
    do_op(2'd2, 13, 32'h4080_0000, 0, got);
    do_op(2'd0, 13, 32'h4040_0000, 0, got);
    check(got, 32'h4080_0000, "R12 sees exchange");
    do_op(2'd1, 13, 32'h4100_0000, 0, got);
    check(got, 32'h4040_0000, "R12 sees minimum");
    do_op(2'd2, 13, ONE, 0, got);
    check(got, 32'h4100_0000, "R12 sees maximum");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = PZ;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_order();
    t_zero();
    t_qnan();
    t_snan();
    t_same();
    t_xchg();
    t_cas();
    t_cas_nan();
    t_b2b();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule